// File: doc/BRIEF.md
# ADC-Synchronized DAC Update Controller

This controller sits between a register write port and a multi-channel DAC core and decides the cycle in which a newly written code reaches each converter input. With synchronization off, or with synchronization on while the ADC is idle, a write reaches the converter input on the next clock edge. With synchronization on while the ADC is busy, the written code is parked in a per-channel pending register. It is released only when the ADC signals that its conversion has finished, so that the DAC does not disturb the shared analog supply while the ADC is sampling.

The ADC completion signal belongs to a different clock domain. It is resynchronized through two flops and turned into a single-cycle pulse by edge detection. Every transfer to a converter input raises a one-cycle start strobe for that channel, but only if the channel's output-enable bit is set. The configuration bits (sync mode and output enables) are write-protected while the ADC is busy. Software has no way to see whether a pending value has been transferred yet.

Top module: `dacsync_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, every `dac_code` lane is 0 and `dac_start` is all zeros. Sync mode and all output enables come out of reset cleared.
- R2: With sync mode off, a data write to channel c sets `dac_code[c]` to the written value on the clock edge that takes the write, whether or not `adc_busy` is high.
- R3: With sync mode on and `adc_busy` low, a data write to channel c sets `dac_code[c]` to the written value on the clock edge that takes the write.
- R4: With sync mode on and `adc_busy` high, a data write leaves `dac_code[c]` unchanged and raises no strobe. The value is transferred on the second clock edge after the first edge that samples `adc_done` high.
- R5: When channel c is written twice while the same conversion is running, only the second value is transferred at completion, with a single strobe.
- R6: `dac_start[c]` rises for exactly the cycle after a transfer to channel c, and only when output-enable bit c (`cfg_out_en[c]`) was set. With the bit at 0, `dac_code[c]` still updates.
- R7: A completion with no pending value changes no code and raises no strobe.
- R8: An `adc_done` level held high for many cycles causes exactly one transfer.
- R9: A configuration write while `adc_busy` is high is ignored. Sync mode and the output enables keep their previous values.
- R10: A data write that falls in the same cycle as the internal completion pulse transfers the new value on that edge and clears the channel's pending state. A later completion then raises no strobe.
- R11: Channels are independent. A write to one channel leaves the other channel's code unchanged, and pending values on several channels all transfer on the same completion edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sync_on | input | 1 | Sync-mode value for a configuration write |
| cfg_out_en | input | NCH | Per-channel output-enable values for a configuration write |
| data_wr | input | 1 | Data write strobe |
| data_ch | input | CHW | Channel index of a data write |
| data_val | input | DW | Code written to the selected channel |
| adc_busy | input | 1 | ADC conversion in progress (peripheral domain level) |
| adc_done | input | 1 | ADC completion level from the ADC clock domain |
| dac_code | output | NCH x DW | Latched converter input code per channel |
| dac_start | output | NCH | One-cycle conversion start strobe per channel |

## Verification
A data write can land in the same cycle as the resynchronized completion pulse. In that cycle, a held transfer of the older value and a direct transfer of the new value compete for the same converter register. The bench provokes this by writing a first value while busy, raising `adc_done`, and issuing the second write in the cycle just before the transfer edge. The case passes if the converter shows the newer value with one strobe, and a following completion produces no strobe and leaves the code as it is.

// File: rtl/dacsync_pkg.sv
package dacsync_pkg;

    localparam int unsigned DEF_NCH = 2;
    localparam int unsigned DEF_DW  = 12;

    // What a channel does on the next clock edge
    typedef enum logic [1:0] {
        ACT_IDLE   = 2'd0,
        ACT_DIRECT = 2'd1,
        ACT_HOLD   = 2'd2,
        ACT_FLUSH  = 2'd3
    } chan_act_e;

    // Per-channel control bundle, built by the top and consumed by a lane
    typedef struct packed {
        logic wr_hit;
        logic sync_on;
        logic busy;
        logic done;
        logic out_en;
    } chan_ctl_t;

    // A write always wins over a flush because it carries the newer value.
    function automatic chan_act_e pick_action(input chan_ctl_t c, input logic pending);
        chan_act_e a;
        a = ACT_IDLE;
        if (c.wr_hit) begin
            if (c.sync_on && c.busy && !c.done)
                a = ACT_HOLD;
            else
                a = ACT_DIRECT;
        end else if (c.done && pending) begin
            a = ACT_FLUSH;
        end
        return a;
    endfunction

endpackage

// File: rtl/dacsync_done_sync.sv
module dacsync_done_sync (
    input  logic clk,
    input  logic rst,
    input  logic done_async,
    output logic done_pulse
);
    logic meta_q;
    logic stab_q;
    logic hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            stab_q <= 1'b0;
            hist_q <= 1'b0;
        end else begin
            meta_q <= done_async;
            stab_q <= meta_q;
            hist_q <= stab_q;
        end
    end

    // rising edge of the resynchronized level
    assign done_pulse = stab_q & ~hist_q;

endmodule

// File: rtl/dacsync_lane.sv
module dacsync_lane
    import dacsync_pkg::*;
#(
    parameter int unsigned DW = DEF_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  chan_ctl_t     ctl,
    input  logic [DW-1:0] wr_val,
    output logic [DW-1:0] code,
    output logic          start
);
    logic [DW-1:0] hold_q;
    logic [DW-1:0] code_q;
    logic          pend_q;
    logic          start_q;
    chan_act_e     act;

    assign act = pick_action(ctl, pend_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            code_q  <= '0;
            pend_q  <= 1'b0;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            unique case (act)
                ACT_DIRECT: begin
                    hold_q  <= wr_val;
                    code_q  <= wr_val;
                    pend_q  <= 1'b0;
                    start_q <= ctl.out_en;
                end
                ACT_HOLD: begin
                    hold_q  <= wr_val;
                    pend_q  <= 1'b1;
                end
                ACT_FLUSH: begin
                    code_q  <= hold_q;
                    pend_q  <= 1'b0;
                    start_q <= ctl.out_en;
                end
                default: ;
            endcase
        end
    end

    assign code  = code_q;
    assign start = start_q;

endmodule

// File: rtl/dacsync_top.sv
module dacsync_top
    import dacsync_pkg::*;
#(
    parameter int unsigned NCH = DEF_NCH,
    parameter int unsigned DW  = DEF_DW,
    localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_wr,
    input  logic                    cfg_sync_on,
    input  logic [NCH-1:0]          cfg_out_en,
    input  logic                    data_wr,
    input  logic [CHW-1:0]          data_ch,
    input  logic [DW-1:0]           data_val,
    input  logic                    adc_busy,
    input  logic                    adc_done,
    output logic [NCH-1:0][DW-1:0]  dac_code,
    output logic [NCH-1:0]          dac_start
);
    logic           sync_q;
    logic [NCH-1:0] oe_q;
    logic           done_pulse;

    // configuration is locked while the ADC converts
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 1'b0;
            oe_q   <= '0;
        end else if (cfg_wr && !adc_busy) begin
            sync_q <= cfg_sync_on;
            oe_q   <= cfg_out_en;
        end
    end

    dacsync_done_sync u_done (
        .clk        (clk),
        .rst        (rst),
        .done_async (adc_done),
        .done_pulse (done_pulse)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_lane
        chan_ctl_t ctl;

        always_comb begin
            ctl.wr_hit  = data_wr && (data_ch == CHW'(g));
            ctl.sync_on = sync_q;
            ctl.busy    = adc_busy;
            ctl.done    = done_pulse;
            ctl.out_en  = oe_q[g];
        end

        dacsync_lane #(.DW(DW)) u_lane (
            .clk    (clk),
            .rst    (rst),
            .ctl    (ctl),
            .wr_val (data_val),
            .code   (dac_code[g]),
            .start  (dac_start[g])
        );
    end

endmodule

// File: rtl/dacsync_chk.sv
module dacsync_chk #(
    parameter int unsigned NCH = 2,
    parameter int unsigned DW  = 12,
    parameter int unsigned CHW = 1
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   cfg_wr,
    input logic                   data_wr,
    input logic [CHW-1:0]         data_ch,
    input logic                   adc_busy,
    input logic                   sync_q,
    input logic [NCH-1:0]         oe_q,
    input logic                   done_pulse,
    input logic [NCH-1:0][DW-1:0] dac_code,
    input logic [NCH-1:0]         dac_start
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (dac_code == '0 && dac_start == '0));

    // R9
    cfg_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && adc_busy) |=> ($stable(sync_q) && $stable(oe_q)));

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_pulse |=> !done_pulse);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        // R6
        start_needs_oe_chk: assert property (@(posedge clk) disable iff (rst)
            dac_start[g] |-> $past(oe_q[g]));

        // R4
        held_no_start_chk: assert property (@(posedge clk) disable iff (rst)
            (sync_q && adc_busy && data_wr && data_ch == CHW'(g) && !done_pulse)
            |=> !dac_start[g]);

        // R7
        code_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            (!(data_wr && data_ch == CHW'(g)) && !done_pulse) |=> $stable(dac_code[g]));
    end

endmodule

bind dacsync_top dacsync_chk #(.NCH(NCH), .DW(DW), .CHW(CHW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_wr     (cfg_wr),
    .data_wr    (data_wr),
    .data_ch    (data_ch),
    .adc_busy   (adc_busy),
    .sync_q     (sync_q),
    .oe_q       (oe_q),
    .done_pulse (done_pulse),
    .dac_code   (dac_code),
    .dac_start  (dac_start)
);

// File: tb/dacsync_top_test.sv
module dacsync_top_test;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_wr = 1'b0;
    logic             cfg_sync_on = 1'b0;
    logic [1:0]       cfg_out_en = '0;
    logic             data_wr = 1'b0;
    logic [0:0]       data_ch = '0;
    logic [11:0]      data_val = '0;
    logic             adc_busy = 1'b0;
    logic             adc_done = 1'b0;
    logic [1:0][11:0] dac_code;
    logic [1:0]       dac_start;

    int n_chk = 0;
    int n_fail = 0;
    int exp_code [2];
    bit finished = 0;

    always #4 clk = ~clk;

    dacsync_top #(.NCH(2), .DW(12)) uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sync_on(cfg_sync_on),
        .cfg_out_en(cfg_out_en), .data_wr(data_wr), .data_ch(data_ch),
        .data_val(data_val), .adc_busy(adc_busy), .adc_done(adc_done),
        .dac_code(dac_code), .dac_start(dac_start)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic cfg(input int s, input int m);
        cfg_wr = 1'b1; cfg_sync_on = s[0]; cfg_out_en = m[1:0];
        tick();
        cfg_wr = 1'b0;
    endtask

    task automatic wr(input int ch, input int v);
        data_wr = 1'b1; data_ch = ch[0]; data_val = v[11:0];
        tick();
        data_wr = 1'b0;
    endtask

    task automatic codes(input string tag);
        check({tag, " code0"}, int'(dac_code[0]), exp_code[0]);
        check({tag, " code1"}, int'(dac_code[1]), exp_code[1]);
    endtask

    function automatic int pat(input int a, input int b);
        return (a * 1187 + b * 613 + 5) % 4096;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int v;
        exp_code[0] = 0; exp_code[1] = 0;
        repeat (3) tick();
        // R1 reset state
        codes("R1 reset");
        check("R1 reset start", int'(dac_start), 0);
        rst = 1'b0;
        tick();
        codes("R1 after release");
        check("R1 after release start", int'(dac_start), 0);

        // R7 completion with nothing pending
        adc_done = 1'b1; tick(); tick(); tick();
        check("R7 idle done start", int'(dac_start), 0);
        codes("R7 idle done");
        adc_done = 1'b0; tick(); tick();

        // R2 R3 R6 R11 sweep over sync, enables, busy, channel
        for (int s = 0; s < 2; s++) begin
            for (int m = 0; m < 4; m++) begin
                cfg(s, m);
                for (int b = 0; b < 2; b++) begin
                    if (s == 1 && b == 1) continue;
                    adc_busy = b[0];
                    for (int ch = 0; ch < 2; ch++) begin
                        v = pat(s * 8 + m * 2 + b, ch);
                        wr(ch, v);
                        exp_code[ch] = v;
                        codes($sformatf("%s R11 s%0d m%0d b%0d ch%0d", (s == 0) ? "R2" : "R3", s, m, b, ch));
                        check($sformatf("R6 start s%0d m%0d b%0d ch%0d", s, m, b, ch),
                              int'(dac_start), ((m >> ch) & 1) << ch);
                    end
                    tick();
                    check("R6 strobe one cycle", int'(dac_start), 0);
                    adc_busy = 1'b0;
                end
            end
        end

        // R4 R5 held writes, one or two per conversion
        cfg(1, 3);
        adc_busy = 1'b1;
        for (int n = 1; n < 3; n++) begin
            for (int ch = 0; ch < 2; ch++) begin
                for (int k = 0; k < n; k++) begin
                    v = pat(40 + n * 4 + ch, k);
                    wr(ch, v);
                    codes("R4 held write");
                    check("R4 held start", int'(dac_start), 0);
                end
                adc_done = 1'b1;
                tick();
                codes("R4 edge k");
                tick();
                codes("R4 edge k+1");
                check("R4 no start before transfer", int'(dac_start), 0);
                tick();
                exp_code[ch] = v;
                codes((n == 2) ? "R5 latest transferred" : "R4 transferred");
                check((n == 2) ? "R5 single start" : "R4 start", int'(dac_start), 1 << ch);
                tick();
                check("R8 no repeat on held done", int'(dac_start), 0);
                repeat (4) tick();
                check("R8 long done level", int'(dac_start), 0);
                codes("R8 long done level");
                adc_done = 1'b0; tick(); tick();
            end
        end

        // R11 both channels pending on one completion
        wr(0, 12'h5A5); wr(1, 12'hA5A);
        codes("R11 both held");
        adc_done = 1'b1; tick(); tick(); tick();
        exp_code[0] = 12'h5A5; exp_code[1] = 12'hA5A;
        codes("R11 both transferred");
        check("R11 both start", int'(dac_start), 3);
        adc_done = 1'b0; tick(); tick();

        // R6 held transfer with output disabled
        adc_busy = 1'b0; cfg(1, 2); adc_busy = 1'b1;
        wr(0, 12'h123);
        adc_done = 1'b1; tick(); tick(); tick();
        exp_code[0] = 12'h123;
        codes("R6 disabled lane updates");
        check("R6 disabled no start", int'(dac_start), 0);
        adc_done = 1'b0; tick(); tick();

        // R9 configuration write while busy is ignored
        cfg(0, 0);
        wr(1, 12'h321);
        codes("R9 sync still on");
        check("R9 sync still on start", int'(dac_start), 0);
        adc_done = 1'b1; tick(); tick(); tick();
        exp_code[1] = 12'h321;
        codes("R9 transfer");
        check("R9 enable kept", int'(dac_start), 2);
        adc_done = 1'b0; tick(); tick();

        // R10 write coinciding with the completion pulse
        adc_busy = 1'b0; cfg(1, 3); adc_busy = 1'b1;
        wr(0, 12'h0F0);
        adc_done = 1'b1; tick(); tick();
        data_wr = 1'b1; data_ch = 1'b0; data_val = 12'hF0F;
        tick();
        data_wr = 1'b0;
        exp_code[0] = 12'hF0F;
        codes("R10 newer value wins");
        check("R10 start", int'(dac_start), 1);
        tick();
        check("R10 one strobe", int'(dac_start), 0);
        adc_done = 1'b0; tick(); tick();
        adc_done = 1'b1; tick(); tick(); tick();
        check("R10 no leftover pending", int'(dac_start), 0);
        codes("R10 no leftover pending");
        adc_done = 1'b0; adc_busy = 1'b0; tick();

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule